// File: doc/BRIEF.md
# Asymmetric Wide-Line Register File

This block holds a small set of wide registers placed between a banked data memory and a scalar datapath. Each register is as wide as one memory line, made of several 32-bit words. On the memory side, a single operation moves a whole line, or any chosen subset of its words, between one register and the memory. The datapath sees each register only one word wide. It reads one word per cycle through a post-decode multiplexer and writes one word per cycle through a demultiplexer. Each access is addressed as register index plus word index.

The data memory is built from one synchronous bank per word lane. Word k of a line always lives in bank k at the line address, so a full-line transfer touches every bank at the same address with no conflict.

Register storage is single-ported. While the memory side holds a register, any datapath access to that same register is refused with a stall, and the memory side always wins. Accesses to other registers proceed normally. The memory side uses a valid/ready handshake. A load takes one cycle to read the banks and fills the register on the following cycle.

Top module: `wide_line_regfile`

## Requirements
- R1: Reset, an active-high synchronous input, clears every word of every register to zero and sets mem_ready to 1. After reset no stall is raised while the memory side is idle.
- R2: A datapath write of a word (wr_en=1, not stalled) becomes visible to a datapath read of that register and word from the next cycle on. Other words of the same register keep their values.
- R3: A datapath read in the same cycle as a write to the same register and word returns the value held before that write.
- R4: In one cycle, the block accepts one datapath read and one datapath write to different registers, and both take effect.
- R5: A store (mem_store=1) accepted by the handshake writes word k of the chosen register into bank k at mem_addr for every k whose mem_mask bit k is 1. Banks whose mask bit is 0 keep their contents at that address.
- R6: A load (mem_store=0) accepted in cycle N reads the banks at mem_addr in cycle N. In cycle N+1 it writes bank k's word into word k of the chosen register for each set mask bit, and words with a clear mask bit keep their values. mem_ready is 0 during cycle N+1 and returns to 1 afterwards.
- R7: The memory side holds a register during the acceptance cycle of a store and during the fill cycle (N+1) of a load. In those cycles, a datapath read of that register raises rd_stall and returns zero on rd_data, and a datapath write to it raises wr_stall and is discarded.
- R8: During the acceptance cycle of a load, no register is held. While a register is held, datapath accesses to any other register raise no stall and complete normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_valid | input | 1 | Memory-side request present |
| mem_ready | output | 1 | Memory side can accept a request |
| mem_store | input | 1 | 1: register to memory, 0: memory to register |
| mem_reg | input | REG_W | Wide register taking part in the transfer |
| mem_addr | input | BANK_AW | Line address, common to all banks |
| mem_mask | input | LANES | Per-word enable of the transfer |
| rd_en | input | 1 | Datapath read request |
| rd_reg | input | REG_W | Register to read |
| rd_word | input | WSEL_W | Word to read within the register |
| rd_data | output | 32 | Read word, zero when stalled or idle |
| rd_stall | output | 1 | Read refused because the memory side holds the register |
| wr_en | input | 1 | Datapath write request |
| wr_reg | input | REG_W | Register to write |
| wr_word | input | WSEL_W | Word to write within the register |
| wr_data | input | 32 | Word to write |
| wr_stall | output | 1 | Write refused and discarded |

## Verification
The main function is driven with single-word writes followed by reads of the same and of neighbouring words, which separates correct word demultiplexing from writes that spill into other lanes. A same-cycle read and write of one word shows whether writes are clocked or fall through. Full-mask and sparse-mask stores and loads show whether the mask gates each lane independently in both directions: a sparse store followed by a full load reveals which banks were touched. Datapath accesses placed in the store cycle, the load acceptance cycle and the load fill cycle, aimed at both the held register and at others, show whether the block stalls exactly the held register in exactly the held cycles.

// File: rtl/wlrf_pkg.sv
package wlrf_pkg;

    localparam int WORD_W = 32;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic {
        XFER_LOAD  = 1'b0,
        XFER_STORE = 1'b1
    } xfer_dir_e;

    typedef struct packed {
        logic      active;
        xfer_dir_e dir;
    } xfer_t;

    function automatic int idx_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/wlrf_bank.sv
module wlrf_bank
    import wlrf_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] addr,
    input  word_t         wdata,
    output word_t         rdata
);
    localparam int DEPTH = 1 << AW;

    word_t cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[addr] <= wdata;
        end
        if (re) begin
            rdata <= cells[addr];
        end
    end
endmodule

// File: rtl/wlrf_row.sv
module wlrf_row
    import wlrf_pkg::*;
#(
    parameter int LANES = 4,
    localparam int WSEL_W = idx_bits(LANES)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         line_we,
    input  logic [LANES-1:0]             line_mask,
    input  logic [LANES-1:0][WORD_W-1:0] line_data,
    input  logic                         word_we,
    input  logic [WSEL_W-1:0]            word_sel,
    input  word_t                        word_data,
    output logic [LANES-1:0][WORD_W-1:0] line_q
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                line_q[k] <= '0;
            end else if (line_we && line_mask[k]) begin
                line_q[k] <= line_data[k];
            end else if (word_we && (word_sel == WSEL_W'(k))) begin
                line_q[k] <= word_data;
            end
        end
    end
endmodule

// File: rtl/wlrf_arbiter.sv
module wlrf_arbiter
    import wlrf_pkg::*;
#(
    parameter int NREGS = 3,
    parameter int LANES = 4,
    localparam int REG_W = idx_bits(NREGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mem_valid,
    input  logic             mem_store,
    input  logic [REG_W-1:0] mem_reg,
    input  logic [LANES-1:0] mem_mask,
    input  logic             rd_en,
    input  logic [REG_W-1:0] rd_reg,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_reg,
    output logic             mem_ready,
    output xfer_t            fire,
    output logic             fill_valid,
    output logic [REG_W-1:0] fill_reg,
    output logic [LANES-1:0] fill_mask,
    output logic             rd_stall,
    output logic             wr_stall
);
    logic             held;
    logic [REG_W-1:0] held_reg;

    assign mem_ready = !fill_valid;

    always_comb begin
        fire.active = mem_valid && mem_ready && !rst;
        fire.dir    = mem_store ? XFER_STORE : XFER_LOAD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_valid <= 1'b0;
            fill_reg   <= '0;
            fill_mask  <= '0;
        end else begin
            fill_valid <= fire.active && (fire.dir == XFER_LOAD);
            if (fire.active && (fire.dir == XFER_LOAD)) begin
                fill_reg  <= mem_reg;
                fill_mask <= mem_mask;
            end
        end
    end

    always_comb begin
        held     = fill_valid || (fire.active && (fire.dir == XFER_STORE));
        held_reg = fill_valid ? fill_reg : mem_reg;
        rd_stall = rd_en && held && (rd_reg == held_reg);
        wr_stall = wr_en && held && (wr_reg == held_reg);
    end
endmodule

// File: rtl/wide_line_regfile.sv
module wide_line_regfile
    import wlrf_pkg::*;
#(
    parameter int LANES   = 4,
    parameter int NREGS   = 3,
    parameter int BANK_AW = 8,
    localparam int REG_W  = idx_bits(NREGS),
    localparam int WSEL_W = idx_bits(LANES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mem_valid,
    output logic              mem_ready,
    input  logic              mem_store,
    input  logic [REG_W-1:0]  mem_reg,
    input  logic [BANK_AW-1:0] mem_addr,
    input  logic [LANES-1:0]  mem_mask,
    input  logic              rd_en,
    input  logic [REG_W-1:0]  rd_reg,
    input  logic [WSEL_W-1:0] rd_word,
    output logic [31:0]       rd_data,
    output logic              rd_stall,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_reg,
    input  logic [WSEL_W-1:0] wr_word,
    input  logic [31:0]       wr_data,
    output logic              wr_stall
);
    typedef logic [LANES-1:0][WORD_W-1:0] line_t;

    xfer_t            fire;
    logic             fill_valid;
    logic [REG_W-1:0] fill_reg;
    logic [LANES-1:0] fill_mask;
    line_t            rows_q [NREGS];
    line_t            store_line;
    line_t            bank_q;

    wlrf_arbiter #(.NREGS(NREGS), .LANES(LANES)) u_arb (
        .clk        (clk),
        .rst        (rst),
        .mem_valid  (mem_valid),
        .mem_store  (mem_store),
        .mem_reg    (mem_reg),
        .mem_mask   (mem_mask),
        .rd_en      (rd_en),
        .rd_reg     (rd_reg),
        .wr_en      (wr_en),
        .wr_reg     (wr_reg),
        .mem_ready  (mem_ready),
        .fire       (fire),
        .fill_valid (fill_valid),
        .fill_reg   (fill_reg),
        .fill_mask  (fill_mask),
        .rd_stall   (rd_stall),
        .wr_stall   (wr_stall)
    );

    for (genvar r = 0; r < NREGS; r++) begin : g_row
        wlrf_row #(.LANES(LANES)) u_row (
            .clk       (clk),
            .rst       (rst),
            .line_we   (fill_valid && (fill_reg == REG_W'(r))),
            .line_mask (fill_mask),
            .line_data (bank_q),
            .word_we   (wr_en && !wr_stall && (wr_reg == REG_W'(r))),
            .word_sel  (wr_word),
            .word_data (wr_data),
            .line_q    (rows_q[r])
        );
    end

    always_comb begin
        store_line = '0;
        for (int r = 0; r < NREGS; r++) begin
            if (mem_reg == REG_W'(r)) begin
                store_line = rows_q[r];
            end
        end
    end

    for (genvar k = 0; k < LANES; k++) begin : g_bank
        wlrf_bank #(.AW(BANK_AW)) u_bank (
            .clk   (clk),
            .we    (fire.active && (fire.dir == XFER_STORE) && mem_mask[k]),
            .re    (fire.active && (fire.dir == XFER_LOAD)),
            .addr  (mem_addr),
            .wdata (store_line[k]),
            .rdata (bank_q[k])
        );
    end

    always_comb begin
        rd_data = '0;
        if (rd_en && !rd_stall) begin
            for (int r = 0; r < NREGS; r++) begin
                if (rd_reg == REG_W'(r)) begin
                    rd_data = rows_q[r][rd_word];
                end
            end
        end
    end
endmodule

// File: rtl/wide_line_regfile_chk.sv
module wide_line_regfile_chk
    import wlrf_pkg::*;
#(
    parameter int LANES = 4,
    parameter int NREGS = 3,
    localparam int REG_W  = idx_bits(NREGS),
    localparam int WSEL_W = idx_bits(LANES)
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic              mem_store,
    input logic [REG_W-1:0]  mem_reg,
    input logic              rd_en,
    input logic [REG_W-1:0]  rd_reg,
    input logic [WSEL_W-1:0] rd_word,
    input logic [31:0]       rd_data,
    input logic              rd_stall,
    input logic              wr_en,
    input logic [REG_W-1:0]  wr_reg,
    input logic [WSEL_W-1:0] wr_word,
    input logic [31:0]       wr_data,
    input logic              wr_stall
);
    a_r1_ready_after_reset: assert property (@(posedge clk)
        rst |=> mem_ready);

    a_r6_ready_drops_after_load: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_ready && !mem_store) |=> !mem_ready);

    a_r6_ready_returns: assert property (@(posedge clk) disable iff (rst)
        !mem_ready |=> mem_ready);

    a_r7_stalled_read_zero: assert property (@(posedge clk) disable iff (rst)
        rd_stall |-> (rd_data == '0));

    a_r7_store_blocks_write: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_ready && mem_store && wr_en && (wr_reg == mem_reg)) |-> wr_stall);

    a_r8_store_spares_other_read: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_ready && mem_store && rd_en && (rd_reg != mem_reg)) |-> !rd_stall);

    a_r8_load_accept_free: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_ready && !mem_store && mem_ready) |-> (!rd_stall && !wr_stall));

    a_r2_write_then_read: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_stall) |=>
            (!(rd_en && !rd_stall && (rd_reg == $past(wr_reg)) && (rd_word == $past(wr_word)))
             || (rd_data == $past(wr_data))));
endmodule

bind wide_line_regfile wide_line_regfile_chk #(.LANES(LANES), .NREGS(NREGS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_store (mem_store),
    .mem_reg   (mem_reg),
    .rd_en     (rd_en),
    .rd_reg    (rd_reg),
    .rd_word   (rd_word),
    .rd_data   (rd_data),
    .rd_stall  (rd_stall),
    .wr_en     (wr_en),
    .wr_reg    (wr_reg),
    .wr_word   (wr_word),
    .wr_data   (wr_data),
    .wr_stall  (wr_stall)
);

// File: tb/wide_line_regfile_bench.sv
`timescale 1ns/1ps
module wide_line_regfile_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        mem_valid, mem_store;
    logic        mem_ready;
    logic [1:0]  mem_reg;
    logic [7:0]  mem_addr;
    logic [3:0]  mem_mask;
    logic        rd_en, wr_en;
    logic [1:0]  rd_reg, rd_word, wr_reg, wr_word;
    logic [31:0] rd_data, wr_data;
    logic        rd_stall, wr_stall;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    wide_line_regfile u_wide_line_regfile (
        .clk(clk), .rst(rst),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_store(mem_store),
        .mem_reg(mem_reg), .mem_addr(mem_addr), .mem_mask(mem_mask),
        .rd_en(rd_en), .rd_reg(rd_reg), .rd_word(rd_word),
        .rd_data(rd_data), .rd_stall(rd_stall),
        .wr_en(wr_en), .wr_reg(wr_reg), .wr_word(wr_word),
        .wr_data(wr_data), .wr_stall(wr_stall)
    );

    typedef struct packed {
        logic        mv;
        logic        mst;
        logic [1:0]  mreg;
        logic [7:0]  maddr;
        logic [3:0]  mmask;
        logic        re;
        logic [1:0]  rreg;
        logic [1:0]  rword;
        logic        we;
        logic [1:0]  wreg;
        logic [1:0]  wword;
        logic [31:0] wdata;
        logic [31:0] erd;
        logic        ers;
        logic        ews;
        logic        erdy;
        logic [3:0]  tag;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{0,0,0,0,4'h0, 1,0,0, 0,0,0,32'h0,    32'h0,    0,0,1, 4'd1}, // R1 idle, zero
        '{0,0,0,0,4'h0, 1,0,1, 1,0,1,32'hA1,   32'h0,    0,0,1, 4'd3}, // R3 old value
        '{0,0,0,0,4'h0, 1,0,1, 1,1,3,32'hB3,   32'hA1,   0,0,1, 4'd2}, // R2 visible next
        '{0,0,0,0,4'h0, 1,1,3, 1,0,0,32'hA0,   32'hB3,   0,0,1, 4'd4}, // R4 rd+wr
        '{0,0,0,0,4'h0, 1,1,0, 1,0,2,32'hA2,   32'h0,    0,0,1, 4'd2}, // R2 other word
        '{0,0,0,0,4'h0, 0,0,0, 1,0,3,32'hA3,   32'h0,    0,0,1, 4'd2},
        '{1,1,0,5,4'hF, 1,0,0, 1,1,0,32'hB0,   32'h0,    1,0,1, 4'd7}, // R7 store holds r0, R8 r1 free
        '{1,0,2,5,4'h5, 0,0,0, 1,2,1,32'hC1,   32'h0,    0,0,1, 4'd8}, // R8 load accept free
        '{0,0,0,0,4'h0, 1,1,0, 1,2,3,32'hC3,   32'hB0,   0,1,0, 4'd6}, // R6 fill, R7 write dropped
        '{0,0,0,0,4'h0, 1,2,0, 0,0,0,32'h0,    32'hA0,   0,0,1, 4'd6}, // R6 lane 0 loaded
        '{0,0,0,0,4'h0, 1,2,1, 0,0,0,32'h0,    32'hC1,   0,0,1, 4'd6}, // R6 masked lane kept
        '{0,0,0,0,4'h0, 1,2,2, 0,0,0,32'h0,    32'hA2,   0,0,1, 4'd6},
        '{0,0,0,0,4'h0, 1,2,3, 1,1,1,32'hB1,   32'h0,    0,0,1, 4'd7}, // R7 dropped write left 0
        '{1,1,1,5,4'h2, 1,2,0, 0,0,0,32'h0,    32'hA0,   0,0,1, 4'd8}, // R8 other reg during store
        '{1,0,1,5,4'hF, 0,0,0, 0,0,0,32'h0,    32'h0,    0,0,1, 4'd6},
        '{0,0,0,0,4'h0, 1,1,3, 0,0,0,32'h0,    32'h0,    1,0,0, 4'd7}, // R7 read stalls in fill
        '{0,0,0,0,4'h0, 1,1,0, 0,0,0,32'h0,    32'hA0,   0,0,1, 4'd5}, // R5 bank0 untouched
        '{0,0,0,0,4'h0, 1,1,1, 0,0,0,32'h0,    32'hB1,   0,0,1, 4'd5}, // R5 bank1 stored
        '{0,0,0,0,4'h0, 1,1,2, 0,0,0,32'h0,    32'hA2,   0,0,1, 4'd5},
        '{0,0,0,0,4'h0, 1,1,3, 0,0,0,32'h0,    32'hA3,   0,0,1, 4'd5}
    };

    task automatic check(input int tag, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic idle();
        mem_valid = 0; mem_store = 0; mem_reg = 0; mem_addr = 0; mem_mask = 0;
        rd_en = 0; rd_reg = 0; rd_word = 0;
        wr_en = 0; wr_reg = 0; wr_word = 0; wr_data = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog all requirements actual=timeout expected=finished");
        finish_run();
    end

    initial begin
        idle();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            mem_valid = VECS[i].mv;    mem_store = VECS[i].mst;
            mem_reg   = VECS[i].mreg;  mem_addr  = VECS[i].maddr;
            mem_mask  = VECS[i].mmask;
            rd_en     = VECS[i].re;    rd_reg    = VECS[i].rreg;
            rd_word   = VECS[i].rword;
            wr_en     = VECS[i].we;    wr_reg    = VECS[i].wreg;
            wr_word   = VECS[i].wword; wr_data   = VECS[i].wdata;
            #1;
            check(VECS[i].tag, "mem_ready", {31'b0, mem_ready}, {31'b0, VECS[i].erdy});
            check(VECS[i].tag, "rd_stall",  {31'b0, rd_stall},  {31'b0, VECS[i].ers});
            check(VECS[i].tag, "wr_stall",  {31'b0, wr_stall},  {31'b0, VECS[i].ews});
            if (VECS[i].re) begin
                check(VECS[i].tag, "rd_data", rd_data, VECS[i].erd);
            end
        end

        // R1: reset mid-stream clears registers and raises ready
        @(negedge clk);
        idle();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        rd_en = 1; rd_reg = 0; rd_word = 1;
        #1;
        check(1, "rd_data after reset", rd_data, 32'h0);
        check(1, "mem_ready after reset", {31'b0, mem_ready}, 32'h1);
        check(1, "rd_stall after reset", {31'b0, rd_stall}, 32'h0);

        // R3: same-cycle write and read of one word after reset
        @(negedge clk);
        rd_reg = 2; rd_word = 2;
        wr_en = 1; wr_reg = 2; wr_word = 2; wr_data = 32'h5A5A_0002;
        #1;
        check(3, "same-cycle read", rd_data, 32'h0);
        @(negedge clk);
        wr_en = 0;
        #1;
        check(2, "read after write", rd_data, 32'h5A5A_0002);
        rd_word = 3;
        #1;
        check(2, "neighbour word untouched", rd_data, 32'h0);

        @(negedge clk);
        idle();
        finish_run();
    end
endmodule